// File: doc/BRIEF.md
# Shared-Adder Four-Bit Arithmetic Unit

This block computes one of eight arithmetic functions of two 4-bit operands and a carry input. The function is picked by a 4-bit opcode whose used codes are not contiguous. Each arithmetic function is reduced to the sum of two addends plus the carry input. A decoder maps the opcode to a pair of term selections. Two term multiplexers then pick the addends from a small set of precomputed terms:

- zero
- A
- B
- A AND B
- A OR B
- A OR NOT B
- A AND NOT B
- all ones
- inverted B
- A shifted left by one

Only a single adder exists in the block. Its low four bits form the result and its fifth bit forms the carry flag.

A mode select of 1 bypasses the arithmetic path, and the outputs go to zero. A parameter chooses between a purely combinational output and an output stage registered on the rising clock edge with a synchronous reset.

Top module: `alu4_shared_add`

## Requirements
- R1: With mode 0 and opcode 0, the addends are A and 4'hF, so the result is (A - 1 + cin) mod 16.
- R2: With mode 0 and opcode 5, the result is ((A AND B) + (A OR NOT B) + cin) mod 16.
- R3: With mode 0 and opcode 6, the addends are A and NOT B, so the result is (A - B - 1 + cin) mod 16.
- R4: With mode 0 and opcode 7, the result is ((A OR NOT B) + cin) mod 16, and the second addend is zero.
- R5: With mode 0, opcode 8 gives (A + (A OR B) + cin) mod 16 and opcode 9 gives (A + B + cin) mod 16.
- R6: With mode 0 and opcode 10, the result is ((A AND NOT B) + (A OR B) + cin) mod 16.
- R7: With mode 0 and opcode 12, the addends are A and (2A mod 16), so the result is (3A + cin) mod 16.
- R8: With mode 1, the result and the carry flag are both 0 for every opcode, operand and carry input.
- R9: With mode 0 and any opcode outside {0,5,6,7,8,9,10,12}, the result and the carry flag are both 0, whatever the carry input is.
- R10: For the listed opcodes, the carry flag equals bit 4 of the unreduced 5-bit sum of the two 4-bit addends and the carry input.
- R11: With PIPE_EN=1, the result and the carry flag appear one rising clock edge after their inputs and hold between edges. A high rst at a rising edge clears both outputs to 0. With PIPE_EN=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | DATA_W (4) | Operand A |
| b_in | input | DATA_W (4) | Operand B |
| op_in | input | OP_W (4) | Function opcode |
| mode_in | input | 1 | 0 = arithmetic, 1 = bypass (outputs zero) |
| cin_in | input | 1 | Carry input added to the sum |
| res_out | output | DATA_W (4) | Result, low bits of the sum |
| cout_out | output | 1 | Carry flag, bit DATA_W of the sum |

## Verification
With the default PIPE_EN=1, every result and carry flag is due at the first rising edge after the inputs are applied. With PIPE_EN=0, they are due as soon as the inputs settle. The bench drives inputs on the falling edge. It then samples 2 ns after the capturing rising edge, or 2 ns after driving when the block is combinational. A dedicated check confirms that, with the register present, new operands do not change the outputs before that edge. Reset is checked both at start-up and in the middle of a run, with inputs that would otherwise give a nonzero result.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

   // opcode values; their positions are behaviour and must stay fixed
   localparam int OPC_DEC     = 0;
   localparam int OPC_AND_ORN = 5;
   localparam int OPC_SUB     = 6;
   localparam int OPC_ORN     = 7;
   localparam int OPC_A_OR    = 8;
   localparam int OPC_ADD     = 9;
   localparam int OPC_ANDN_OR = 10;
   localparam int OPC_TRIPLE  = 12;

   typedef enum logic [3:0] {
      TERM_ZERO,
      TERM_A,
      TERM_B,
      TERM_AND,
      TERM_OR,
      TERM_ORN,
      TERM_ANDN,
      TERM_ONES,
      TERM_NOTB,
      TERM_A2
   } term_sel_e;

   typedef struct packed {
      term_sel_e lhs;
      term_sel_e rhs;
      logic      cin_en;
   } operand_sel_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import alu4_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic [OP_W-1:0] op_i,
   input  logic            mode_i,
   output operand_sel_t    sel_o
);

   always_comb begin
      sel_o.lhs    = TERM_ZERO;
      sel_o.rhs    = TERM_ZERO;
      sel_o.cin_en = 1'b0;
      if (!mode_i) begin
         sel_o.cin_en = 1'b1;
         case (op_i)
            OP_W'(OPC_DEC): begin
               sel_o.lhs = TERM_A;
               sel_o.rhs = TERM_ONES;
            end
            OP_W'(OPC_AND_ORN): begin
               sel_o.lhs = TERM_AND;
               sel_o.rhs = TERM_ORN;
            end
            OP_W'(OPC_SUB): begin
               sel_o.lhs = TERM_A;
               sel_o.rhs = TERM_NOTB;
            end
            OP_W'(OPC_ORN): begin
               sel_o.lhs = TERM_ORN;
               sel_o.rhs = TERM_ZERO;
            end
            OP_W'(OPC_A_OR): begin
               sel_o.lhs = TERM_A;
               sel_o.rhs = TERM_OR;
            end
            OP_W'(OPC_ADD): begin
               sel_o.lhs = TERM_A;
               sel_o.rhs = TERM_B;
            end
            OP_W'(OPC_ANDN_OR): begin
               sel_o.lhs = TERM_ANDN;
               sel_o.rhs = TERM_OR;
            end
            OP_W'(OPC_TRIPLE): begin
               sel_o.lhs = TERM_A;
               sel_o.rhs = TERM_A2;
            end
            default: begin
               sel_o.cin_en = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/alu_term_mux.sv
module alu_term_mux
   import alu4_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  term_sel_e         sel_i,
   output logic [DATA_W-1:0] term_o
);

   always_comb begin
      case (sel_i)
         TERM_A:    term_o = a_i;
         TERM_B:    term_o = b_i;
         TERM_AND:  term_o = a_i & b_i;
         TERM_OR:   term_o = a_i | b_i;
         TERM_ORN:  term_o = a_i | ~b_i;
         TERM_ANDN: term_o = a_i & ~b_i;
         TERM_ONES: term_o = '1;
         TERM_NOTB: term_o = ~b_i;
         TERM_A2:   term_o = {a_i[DATA_W-2:0], 1'b0};
         default:   term_o = '0;
      endcase
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int DATA_W = 4
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o
);

   localparam int FULL_W = DATA_W + 1;

   logic [FULL_W-1:0] full_sum;

   assign full_sum = {1'b0, x_i} + {1'b0, y_i} + FULL_W'(cin_i);
   assign sum_o    = full_sum[DATA_W-1:0];
   assign cout_o   = full_sum[DATA_W];

endmodule

// File: rtl/alu4_shared_add.sv
module alu4_shared_add
   import alu4_pkg::*;
#(
   parameter int DATA_W  = 4,
   parameter int OP_W    = 4,
   parameter bit PIPE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [OP_W-1:0]   op_in,
   input  logic              mode_in,
   input  logic              cin_in,
   output logic [DATA_W-1:0] res_out,
   output logic              cout_out
);

   localparam int N_ADDENDS = 2;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("alu4_shared_add: DATA_W must be at least 2");
   end
   if (OP_W < 4) begin : g_bad_op_w
      $error("alu4_shared_add: OP_W must be at least 4 to hold every opcode");
   end

   operand_sel_t      sel;
   term_sel_e         pick   [N_ADDENDS];
   logic [DATA_W-1:0] addend [N_ADDENDS];
   logic [DATA_W-1:0] core_res;
   logic              core_cout;

   alu_op_decode #(.OP_W(OP_W)) i_decode (
      .op_i   (op_in),
      .mode_i (mode_in),
      .sel_o  (sel)
   );

   assign pick[0] = sel.lhs;
   assign pick[1] = sel.rhs;

   for (genvar g = 0; g < N_ADDENDS; g++) begin : g_mux
      alu_term_mux #(.DATA_W(DATA_W)) i_mux (
         .a_i    (a_in),
         .b_i    (b_in),
         .sel_i  (pick[g]),
         .term_o (addend[g])
      );
   end

   alu_adder #(.DATA_W(DATA_W)) i_adder (
      .x_i    (addend[0]),
      .y_i    (addend[1]),
      .cin_i  (cin_in & sel.cin_en),
      .sum_o  (core_res),
      .cout_o (core_cout)
   );

   if (PIPE_EN) begin : g_reg
      logic [DATA_W-1:0] res_q;
      logic              cout_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            res_q  <= '0;
            cout_q <= 1'b0;
         end else begin
            res_q  <= core_res;
            cout_q <= core_cout;
         end
      end

      assign res_out  = res_q;
      assign cout_out = cout_q;

      assert_pipe_latency_R11: assert property (@(posedge clk) disable iff (rst)
         !rst |=> (res_out == $past(core_res)) && (cout_out == $past(core_cout)));
   end else begin : g_comb
      assign res_out  = core_res;
      assign cout_out = core_cout;
   end

   // bypass mode forces a zero adder output
   assert_mode_bypass_R8: assert property (@(posedge clk) disable iff (rst)
      mode_in |-> (core_res == '0) && !core_cout);

   // opcodes without a function produce zero and ignore the carry input
   assert_unlisted_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (!mode_in && !(op_in inside {OP_W'(OPC_DEC), OP_W'(OPC_AND_ORN), OP_W'(OPC_SUB),
                                   OP_W'(OPC_ORN), OP_W'(OPC_A_OR), OP_W'(OPC_ADD),
                                   OP_W'(OPC_ANDN_OR), OP_W'(OPC_TRIPLE)}))
      |-> (core_res == '0) && !core_cout);

   // plain add, carry taken from the fifth sum bit
   assert_add_carry_R5: assert property (@(posedge clk) disable iff (rst)
      (!mode_in && op_in == OP_W'(OPC_ADD))
      |-> {core_cout, core_res} == ({1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin_in}));

   // subtract through inverted B
   assert_sub_R3: assert property (@(posedge clk) disable iff (rst)
      (!mode_in && op_in == OP_W'(OPC_SUB))
      |-> core_res == DATA_W'(a_in - b_in - DATA_W'(1) + DATA_W'(cin_in)));

   // decrement: carry set unless A is zero and no carry comes in
   assert_dec_carry_R10: assert property (@(posedge clk) disable iff (rst)
      (!mode_in && op_in == OP_W'(OPC_DEC))
      |-> core_cout == ((a_in != '0) || cin_in));

endmodule

// File: tb/test_alu4_shared_add.sv
module test_alu4_shared_add;
   timeunit 1ns;
   timeprecision 1ps;

   localparam bit PIPE = 1'b1;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] a, b, op;
   logic       mode, cin;
   logic [3:0] res;
   logic       cout;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   alu4_shared_add #(.DATA_W(4), .OP_W(4), .PIPE_EN(PIPE)) i_alu4_shared_add (
      .clk      (clk),
      .rst      (rst),
      .a_in     (a),
      .b_in     (b),
      .op_in    (op),
      .mode_in  (mode),
      .cin_in   (cin),
      .res_out  (res),
      .cout_out (cout)
   );

   // {mode, opcode, a, b, cin}
   localparam logic [13:0] VEC [16] = '{
      {1'b0, 4'd0,  4'd0,  4'd3,  1'b0},
      {1'b0, 4'd0,  4'd0,  4'd3,  1'b1},
      {1'b0, 4'd5,  4'd12, 4'd10, 1'b0},
      {1'b0, 4'd6,  4'd3,  4'd5,  1'b0},
      {1'b0, 4'd6,  4'd9,  4'd4,  1'b1},
      {1'b0, 4'd7,  4'd2,  4'd6,  1'b1},
      {1'b0, 4'd8,  4'd15, 4'd1,  1'b1},
      {1'b0, 4'd9,  4'd15, 4'd15, 1'b1},
      {1'b0, 4'd9,  4'd7,  4'd8,  1'b0},
      {1'b0, 4'd10, 4'd13, 4'd6,  1'b0},
      {1'b0, 4'd12, 4'd9,  4'd0,  1'b1},
      {1'b0, 4'd12, 4'd5,  4'd0,  1'b0},
      {1'b0, 4'd3,  4'd15, 4'd15, 1'b1},
      {1'b0, 4'd15, 4'd8,  4'd8,  1'b1},
      {1'b1, 4'd9,  4'd15, 4'd15, 1'b1},
      {1'b1, 4'd0,  4'd1,  4'd1,  1'b0}
   };

   // expected {carry, result} from the requirement formulas
   function automatic logic [4:0] model(input logic m, input logic [3:0] o,
                                         input logic [3:0] x, input logic [3:0] y,
                                         input logic c);
      logic [3:0] p, q;
      logic       ok;
      ok = 1'b1;
      p  = 4'd0;
      q  = 4'd0;
      case (o)
         4'd0:  begin p = x;      q = 4'hF;   end
         4'd5:  begin p = x & y;  q = x | ~y; end
         4'd6:  begin p = x;      q = ~y;     end
         4'd7:  begin p = x | ~y; q = 4'd0;   end
         4'd8:  begin p = x;      q = x | y;  end
         4'd9:  begin p = x;      q = y;      end
         4'd10: begin p = x & ~y; q = x | y;  end
         4'd12: begin p = x;      q = {x[2:0], 1'b0}; end
         default: ok = 1'b0;
      endcase
      if (m || !ok) return 5'd0;
      return {1'b0, p} + {1'b0, q} + {4'd0, c};
   endfunction

   function automatic string req_of(input logic m, input logic [3:0] o);
      if (m) return "R8";
      case (o)
         4'd0:  return "R1/R10";
         4'd5:  return "R2/R10";
         4'd6:  return "R3/R10";
         4'd7:  return "R4/R10";
         4'd8, 4'd9: return "R5/R10";
         4'd10: return "R6/R10";
         4'd12: return "R7/R10";
         default: return "R9";
      endcase
   endfunction

   task automatic expect_out(input string tag, input logic [4:0] exp);
      checks++;
      if ({cout, res} !== exp) begin
         fails++;
         $display("FAIL %s: got carry=%0b result=%0d, expected carry=%0b result=%0d",
                  tag, cout, res, exp[4], exp[3:0]);
      end
   endtask

   task automatic run_vec(input logic m, input logic [3:0] o, input logic [3:0] x,
                          input logic [3:0] y, input logic c);
      @(negedge clk);
      mode = m; op = o; a = x; b = y; cin = c;
      if (PIPE) @(posedge clk);
      #2;
      expect_out(req_of(m, o), model(m, o, x, y, c));
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; mode = 1'b0; op = 4'd9; a = 4'd15; b = 4'd15; cin = 1'b1;
      repeat (2) @(posedge clk);
      #2;
      // R11: reset state clears outputs despite nonzero-producing inputs
      if (PIPE) expect_out("R11 reset", 5'd0);
      @(negedge clk);
      rst = 1'b0;

      // table of vectors
      for (int i = 0; i < 16; i++) begin
         run_vec(VEC[i][13], VEC[i][12:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
      end

      // exhaustive arithmetic-mode sweep (R1..R7, R9, R10)
      for (int o = 0; o < 16; o++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               for (int c = 0; c < 2; c++) begin
                  run_vec(1'b0, 4'(o), 4'(x), 4'(y), 1'(c));
               end
            end
         end
      end

      // R8: bypass for every opcode with all-ones operands and carry
      for (int o = 0; o < 16; o++) begin
         run_vec(1'b1, 4'(o), 4'hF, 4'hF, 1'b1);
      end

      if (PIPE) begin
         // R11: outputs hold until the next rising edge
         run_vec(1'b0, 4'd9, 4'd1, 4'd1, 1'b0);
         @(negedge clk);
         a = 4'd5; b = 4'd5;
         #2;
         expect_out("R11 hold before edge", 5'd2);
         @(posedge clk);
         #2;
         expect_out("R11 update after edge", 5'd10);

         // R11: reset in mid-run
         @(negedge clk);
         op = 4'd9; a = 4'd15; b = 4'd15; cin = 1'b1; rst = 1'b1;
         @(posedge clk);
         #2;
         expect_out("R11 mid-run reset", 5'd0);
         @(negedge clk);
         rst = 1'b0;
         @(posedge clk);
         #2;
         expect_out("R11 after reset release", 5'd31);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule